// File: doc/BRIEF.md
# Multiprocessor Bus Interrupt Controller

This block sits on a 32-slot system bus and merges per-slot level-sensitive interrupt requests into one interrupt line per CPU. A request reaches a CPU only when the slot's bit is set in a controller-wide enable mask and also in that CPU's own routing mask. Each CPU also has an inter-processor interrupt bit that software raises and drops. That bit is merged into the same output line.

Software accesses the block through a single-cycle register port with 32-bit words and byte addresses. The low two address bits are ignored. Every access carries the identity of the CPU that issues it, and a "self" register reads back a one-hot bit for that CPU. The controller also provides:

- a read-only mask of the CPUs that are present;
- a CPU start mask that drives one run output per CPU;
- a few scratch words per CPU for start-up parameters such as the entry address and the software CPU number;
- a read-only RAM size;
- read-only identification words;
- a sticky power-off request.

Read data is registered and appears on `rdata_o` one clock edge after the request. The controller registers sit below byte address 0x1000. CPU c owns a 1 KiB region that starts at 0x1000 + 0x400·c.

Top module: `sysbus_irq_ctrl`

## Requirements
- R1: After reset, `irq_o`, `cpu_run_o`, `power_off_o` and `rdata_o` are zero, and the enable mask, every routing mask, every IPI bit and every scratch word read back as zero.
- R2: A read of 0x204 returns `irq_i` as sampled at the request edge, with bit n belonging to slot n. Writes to it are ignored.
- R3: 0x20C is a read/write controller-wide slot enable mask, with bit n belonging to slot n. It changes only when written.
- R4: `irq_o[c]` is 1 exactly when some slot n has its request, its global enable bit and bit n of CPU c's routing mask all set, or when CPU c's IPI bit is set. It is registered and reflects its inputs one clock edge after they change.
- R5: Offset 0x000 of CPU c's region is that CPU's read/write routing mask, and each CPU's mask is independent of the others.
- R6: Offset 0x004 of CPU c's region is the IPI bit. A write stores bit 0 of the write data, and the register reads back as that bit in bit 0.
- R7: 0x210 reads the present-CPU mask parameter, with bit c belonging to CPU c. 0x218 reads a value with only bit `cpu_id_i` set. Both are read-only.
- R8: 0x214 stores the write data ANDed with the present mask, drives `cpu_run_o` from the stored value and reads it back.
- R9: Offsets 0x300 + 4·w of CPU c's region, for w below SCRATCH_WORDS, are independent read/write scratch words.
- R10: A write of zero to 0x208 sets `power_off_o`, which then stays set until reset, and a write of any other value has no effect. A read of 0x208 returns 1 while power is on and 0 once power-off has been requested.
- R11: 0x000, 0x004 and 0x008 read the vendor, device and revision parameters, and 0x200 reads the RAM size parameter. Writes to these offsets are ignored.
- R12: Unmapped addresses read zero and ignore writes. Address bits 1:0 do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| cpu_id_i | input | CPU_IDX_W | Number of the CPU issuing the access |
| rdata_o | output | 32 | Read data, registered |
| irq_i | input | NUM_SLOTS | Level interrupt request per slot |
| irq_o | output | NUM_CPUS | Interrupt line per CPU |
| cpu_run_o | output | NUM_CPUS | Start enable per CPU |
| power_off_o | output | 1 | Sticky power-off request |

## Verification
The routing sweep raises each of the 32 slots alone. Each CPU's routing mask selects the slots whose number modulo four equals the CPU number, so a wrong slot-to-CPU mapping, a crossed bit or a shared mask shows up as a wrong bit of `irq_o`. Each slot is then masked alone in the global enable. This separates the global gate from the per-CPU gate. An all-slots request with all routing masks zero confirms that nothing leaks through, and IPI writes with different bit-0 patterns show that only bit 0 counts and that the IPI bypasses both masks. Scratch words get distinct values per CPU and per word, which exposes aliasing between regions. The present mask has a hole, so the start mask's AND with the present mask is visible.

// File: rtl/sysbus_irq_pkg.sv
package sysbus_irq_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned CTL_SPAN     = 'h1000;  // controller registers below this
  localparam int unsigned CPU_BASE     = 'h1000;
  localparam int unsigned CPU_SPAN_LG2 = 10;      // 1 KiB per CPU region

  // word offsets inside a CPU region
  localparam logic [7:0] W_ROUTE   = 8'h00;
  localparam logic [7:0] W_IPI     = 8'h01;
  localparam logic [7:0] W_SCRATCH = 8'hC0;       // byte 0x300

  typedef enum logic [3:0] {
    G_NONE, G_VENDOR, G_DEVICE, G_REV, G_RAMSZ, G_PEND,
    G_PWR, G_GEN, G_PRESENT, G_RUN, G_SELF
  } glob_sel_e;

  function automatic glob_sel_e decode_glob(input logic [9:0] word);
    case (word)
      10'h000: decode_glob = G_VENDOR;
      10'h001: decode_glob = G_DEVICE;
      10'h002: decode_glob = G_REV;
      10'h080: decode_glob = G_RAMSZ;
      10'h081: decode_glob = G_PEND;
      10'h082: decode_glob = G_PWR;
      10'h083: decode_glob = G_GEN;
      10'h084: decode_glob = G_PRESENT;
      10'h085: decode_glob = G_RUN;
      10'h086: decode_glob = G_SELF;
      default: decode_glob = G_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cpu_local_regs.sv
module cpu_local_regs
  import sysbus_irq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS     = 32,
  parameter int unsigned SCRATCH_WORDS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [7:0]           word_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [NUM_SLOTS-1:0] route_o,
  output logic                 ipi_o,
  output logic [REG_W-1:0]     rdata_o
);
  localparam int unsigned SW_IDX_W = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;
  localparam logic [7:0]  SCR_HI   = 8'(int'(W_SCRATCH) + SCRATCH_WORDS);

  logic [NUM_SLOTS-1:0] route_q;
  logic                 ipi_q;
  logic [REG_W-1:0]     scratch_q [SCRATCH_WORDS];
  logic                 scr_hit;
  logic [7:0]           scr_rel;
  logic [SW_IDX_W-1:0]  scr_idx;

  assign scr_hit = (word_i >= W_SCRATCH) && (word_i < SCR_HI);
  assign scr_rel = word_i - W_SCRATCH;
  assign scr_idx = scr_rel[SW_IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
      ipi_q   <= 1'b0;
    end else if (wr_i) begin
      if (word_i == W_ROUTE) route_q <= wdata_i[NUM_SLOTS-1:0];
      if (word_i == W_IPI)   ipi_q   <= wdata_i[0];
    end
  end

  for (genvar w = 0; w < SCRATCH_WORDS; w++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        scratch_q[w] <= '0;
      else if (wr_i && scr_hit && scr_idx == SW_IDX_W'(w)) scratch_q[w] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (word_i == W_ROUTE)    rdata_o[NUM_SLOTS-1:0] = route_q;
    else if (word_i == W_IPI) rdata_o[0] = ipi_q;
    else if (scr_hit)         rdata_o = scratch_q[scr_idx];
  end

  assign route_o = route_q;
  assign ipi_o   = ipi_q;

  p_ipi_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ipi_q));
  p_route_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(route_q));
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit #(
  parameter int unsigned NUM_SLOTS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] pend_i,
  input  logic [NUM_SLOTS-1:0] gen_en_i,
  input  logic [NUM_SLOTS-1:0] route_i,
  input  logic                 ipi_i,
  output logic                 irq_o
);
  logic hit;
  assign hit = |(pend_i & gen_en_i & route_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= hit | ipi_i;
  end

  p_ipi_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipi_i |=> irq_o);
  p_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ipi_i && ((pend_i & gen_en_i & route_i) == '0)) |=> !irq_o);
endmodule

// File: rtl/sysbus_irq_ctrl.sv
module sysbus_irq_ctrl
  import sysbus_irq_pkg::*;
#(
  parameter int unsigned    NUM_SLOTS     = 32,
  parameter int unsigned    NUM_CPUS      = 4,
  parameter int unsigned    ADDR_W        = 16,
  parameter int unsigned    SCRATCH_WORDS = 4,
  parameter logic [NUM_CPUS-1:0] CPU_PRESENT = '1,
  parameter logic [31:0]    RAM_SIZE      = 32'h0100_0000,
  parameter logic [31:0]    VENDOR_ID     = 32'h0000_0001,
  parameter logic [31:0]    DEVICE_ID     = 32'h0000_0001,
  parameter logic [31:0]    REVISION      = 32'h0000_0001,
  localparam int unsigned   CPU_IDX_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  input  logic [CPU_IDX_W-1:0] cpu_id_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_SLOTS-1:0] irq_i,
  output logic [NUM_CPUS-1:0]  irq_o,
  output logic [NUM_CPUS-1:0]  cpu_run_o,
  output logic                 power_off_o
);
  localparam logic [ADDR_W-1:0] CTL_TOP = ADDR_W'(CTL_SPAN);
  localparam logic [ADDR_W-1:0] CPU_LO  = ADDR_W'(CPU_BASE);
  localparam logic [ADDR_W-1:0] CPU_LEN = ADDR_W'(NUM_CPUS << CPU_SPAN_LG2);

  logic                 wr;
  logic                 glob_hit, cpu_hit;
  glob_sel_e            sel;
  logic [ADDR_W-1:0]    cpu_rel;
  logic [CPU_IDX_W-1:0] cpu_idx;
  logic [7:0]           cpu_word;

  logic [NUM_SLOTS-1:0] gen_q;
  logic [NUM_CPUS-1:0]  run_q;
  logic                 power_q;
  logic [REG_W-1:0]     rd_val;

  logic [NUM_SLOTS-1:0] route  [NUM_CPUS];
  logic [NUM_CPUS-1:0]  ipi;
  logic [REG_W-1:0]     cpu_rd [NUM_CPUS];

  assign wr       = req_i & we_i;
  assign glob_hit = addr_i < CTL_TOP;
  assign sel      = glob_hit ? decode_glob(addr_i[11:2]) : G_NONE;
  assign cpu_rel  = addr_i - CPU_LO;
  assign cpu_hit  = (addr_i >= CPU_LO) && (cpu_rel < CPU_LEN);
  assign cpu_idx  = cpu_rel[CPU_SPAN_LG2 +: CPU_IDX_W];
  assign cpu_word = cpu_rel[CPU_SPAN_LG2-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q   <= '0;
      run_q   <= '0;
      power_q <= 1'b0;
    end else if (wr) begin
      if (sel == G_GEN)                 gen_q   <= wdata_i[NUM_SLOTS-1:0];
      if (sel == G_RUN)                 run_q   <= wdata_i[NUM_CPUS-1:0] & CPU_PRESENT;
      if (sel == G_PWR && wdata_i == '0) power_q <= 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    cpu_local_regs #(
      .NUM_SLOTS    (NUM_SLOTS),
      .SCRATCH_WORDS(SCRATCH_WORDS)
    ) i_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr && cpu_hit && cpu_idx == CPU_IDX_W'(c)),
      .word_i (cpu_word),
      .wdata_i(wdata_i),
      .route_o(route[c]),
      .ipi_o  (ipi[c]),
      .rdata_o(cpu_rd[c])
    );

    irq_route_unit #(.NUM_SLOTS(NUM_SLOTS)) i_route (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pend_i  (irq_i),
      .gen_en_i(gen_q),
      .route_i (route[c]),
      .ipi_i   (ipi[c]),
      .irq_o   (irq_o[c])
    );
  end

  always_comb begin
    rd_val = '0;
    unique case (sel)
      G_VENDOR:  rd_val = VENDOR_ID;
      G_DEVICE:  rd_val = DEVICE_ID;
      G_REV:     rd_val = REVISION;
      G_RAMSZ:   rd_val = RAM_SIZE;
      G_PEND:    rd_val[NUM_SLOTS-1:0] = irq_i;
      G_PWR:     rd_val[0] = ~power_q;
      G_GEN:     rd_val[NUM_SLOTS-1:0] = gen_q;
      G_PRESENT: rd_val[NUM_CPUS-1:0] = CPU_PRESENT;
      G_RUN:     rd_val[NUM_CPUS-1:0] = run_q;
      G_SELF:    rd_val[cpu_id_i] = 1'b1;
      default:   if (cpu_hit) rd_val = cpu_rd[cpu_idx];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_o <= '0;
    else if (req_i && !we_i)   rdata_o <= rd_val;
  end

  assign cpu_run_o   = run_q;
  assign power_off_o = power_q;

  p_power_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_off_o |=> power_off_o);
  p_gen_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && sel == G_GEN) |=> $stable(gen_q));
  p_self_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && sel == G_SELF) |=> ($countones(rdata_o) == 1));
  p_run_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && sel == G_RUN) |=> $stable(cpu_run_o));
endmodule

// File: tb/test_sysbus_irq_ctrl.sv
module test_sysbus_irq_ctrl;
  localparam logic [3:0]  PRESENT = 4'b1011;
  localparam logic [31:0] RAMSZ   = 32'h0200_0000;
  localparam logic [31:0] VID     = 32'h0000_00A5;
  localparam logic [31:0] DID     = 32'h0000_0042;
  localparam logic [31:0] REV     = 32'h0000_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  cpu_id = '0;
  logic [31:0] rdata;
  logic [31:0] irq_in = '0;
  logic [3:0]  irq_out, run;
  logic        pwr_off;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sysbus_irq_ctrl #(
    .CPU_PRESENT(PRESENT), .RAM_SIZE(RAMSZ),
    .VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV)
  ) i_sysbus_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .cpu_id_i(cpu_id), .rdata_o(rdata), .irq_i(irq_in),
    .irq_o(irq_out), .cpu_run_o(run), .power_off_o(pwr_off)
  );

  function automatic logic [15:0] cpu_addr(int c, int off);
    return 16'('h1000 + c * 'h400 + off);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [1:0] id, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; cpu_id = id;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [3:0]  exp_irq;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq_o", 32'(irq_out), 0);
    check("R1 cpu_run_o", 32'(run), 0);
    check("R1 power_off_o", 32'(pwr_off), 0);
    check("R1 rdata_o", rdata, 0);
    rst_n = 1'b1;
    rd(16'h020C, 0, v); check("R1 gen mask", v, 0);
    for (int c = 0; c < 4; c++) begin
      rd(cpu_addr(c, 0), 0, v);     check("R1 route", v, 0);
      rd(cpu_addr(c, 4), 0, v);     check("R1 ipi", v, 0);
      rd(cpu_addr(c, 'h304), 0, v); check("R1 scratch", v, 0);
    end

    // R11 identification and RAM size, read-only
    rd(16'h0000, 0, v); check("R11 vendor", v, VID);
    rd(16'h0004, 0, v); check("R11 device", v, DID);
    rd(16'h0008, 0, v); check("R11 revision", v, REV);
    wr(16'h0200, 32'hFFFF_FFFF);
    wr(16'h0004, 32'h1234_5678);
    rd(16'h0200, 0, v); check("R11 ramsize after write", v, RAMSZ);
    rd(16'h0004, 0, v); check("R11 device after write", v, DID);

    // R7 present and self
    wr(16'h0210, 32'hFFFF_FFFF);
    rd(16'h0210, 0, v); check("R7 present", v, 32'(PRESENT));
    for (int c = 0; c < 4; c++) begin
      rd(16'h0218, 2'(c), v); check("R7 self", v, 32'(1) << c);
    end

    // R8 start mask gated by present
    wr(16'h0214, 32'hFFFF_FFFF);
    check("R8 run all", 32'(run), 32'(PRESENT));
    rd(16'h0214, 0, v); check("R8 run readback", v, 32'(PRESENT));
    wr(16'h0214, 32'h4);
    check("R8 absent cpu", 32'(run), 0);
    wr(16'h0214, 32'h2);
    check("R8 single", 32'(run), 2);

    // R12 unmapped and low address bits
    wr(16'h021C, 32'hDEAD_BEEF);
    rd(16'h021C, 0, v); check("R12 unmapped ctl", v, 0);
    rd(16'h1008, 0, v); check("R12 unmapped cpu", v, 0);
    rd(16'h2000, 0, v); check("R12 past last cpu", v, 0);
    wr(16'h020F, 32'h0000_F00F);
    rd(16'h020E, 0, v); check("R12 low bits ignored", v, 32'h0000_F00F);

    // R9 scratch words, distinct per cpu and word
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 4; w++)
        wr(cpu_addr(c, 'h300 + 4 * w), 32'hC0DE_0000 + 32'(c * 16 + w));
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 4; w++) begin
        rd(cpu_addr(c, 'h300 + 4 * w), 0, v);
        check("R9 scratch", v, 32'hC0DE_0000 + 32'(c * 16 + w));
      end

    // R2 pending register
    irq_in = 32'hA5A5_0F0F;
    wr(16'h0204, 32'h0);
    rd(16'h0204, 0, v); check("R2 pending", v, 32'hA5A5_0F0F);
    irq_in = 32'h8000_0001;
    rd(16'h0204, 0, v); check("R2 pending 2", v, 32'h8000_0001);

    // R4 nothing routed: all requests, routes zero
    irq_in = '1;
    wr(16'h020C, 32'hFFFF_FFFF);
    settle();
    check("R4 no route", 32'(irq_out), 0);
    rd(16'h020C, 0, v); check("R3 gen readback", v, 32'hFFFF_FFFF);

    // R5 routes: cpu c takes slots with n mod 4 == c
    for (int c = 0; c < 4; c++) wr(cpu_addr(c, 0), 32'h1111_1111 << c);
    for (int c = 0; c < 4; c++) begin
      rd(cpu_addr(c, 0), 0, v); check("R5 route readback", v, 32'h1111_1111 << c);
    end

    // R4 sweep
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      irq_in = 32'(1) << s;
      exp_irq = 4'(1) << (s % 4);
      #1;
      if (s > 0) check("R4 registered latency", 32'(irq_out), 32'(4'(1) << ((s - 1) % 4)));
      settle();
      check("R4 routed", 32'(irq_out), 32'(exp_irq));
      wr(16'h020C, ~(32'(1) << s));
      settle();
      check("R4 R3 masked", 32'(irq_out), 0);
      wr(16'h020C, 32'hFFFF_FFFF);
      settle();
    end

    // R6 IPI
    irq_in = '0;
    settle();
    for (int c = 0; c < 4; c++) begin
      wr(cpu_addr(c, 4), 32'h5);
      settle();
      check("R6 ipi set", 32'(irq_out), 32'(4'(1) << c));
      rd(cpu_addr(c, 4), 0, v); check("R6 ipi readback", v, 1);
      wr(cpu_addr(c, 4), 32'h2);
      settle();
      check("R6 ipi clear", 32'(irq_out), 0);
    end
    wr(16'h020C, 32'h0);
    wr(cpu_addr(1, 4), 32'h1);
    settle();
    check("R6 ipi bypasses masks", 32'(irq_out), 2);

    // R10 power
    wr(16'h0208, 32'h1);
    check("R10 nonzero write", 32'(pwr_off), 0);
    rd(16'h0208, 0, v); check("R10 read on", v, 1);
    wr(16'h0208, 32'h0);
    check("R10 off", 32'(pwr_off), 1);
    rd(16'h0208, 0, v); check("R10 read off", v, 0);
    wr(16'h0208, 32'h7);
    check("R10 sticky", 32'(pwr_off), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule